// File: doc/BRIEF.md
# NAND Page ECC Correction Sequencer

This block runs the correction phase for one 512-byte chunk of NAND data protected by a Reed-Solomon code that fixes up to four 10-bit symbols. On a start request it feeds the eight stored check symbols to an external decoder, one per cycle, from the highest index down to the lowest. It then looks at the syndrome the decoder returns. An all-zero syndrome ends the job at once with a pass. Any other syndrome makes it raise a calculation request and follow the decoder's state code through a rise and a settle.

Once the code has settled, the sequencer either finishes or walks the reported error slots. For each slot it turns the decoder location into a byte offset, rejects offsets outside the chunk, and applies the pattern to a local 512x8 page buffer with a read cycle followed by a write cycle. Every exit taken after the calculation request pulses a read strobe toward the decoder, which clears that request. The result comes out as a one-cycle done pulse together with a pass flag.

The page buffer can be reached from outside through a simple host port while the sequencer is idle. Surrounding logic uses that port to fill the chunk before a run and to collect it afterwards.

Top module: `nand_ecc_fixer`

## Requirements
- R1: After synchronous active-high reset, done, pass, busy, dec_load_valid, dec_calc_start and dec_val_rd are all 0.
- R2: A start accepted in idle produces dec_load_valid for 8 consecutive cycles, beginning on the cycle after start. dec_load_sym carries check symbol 7 first and symbol 0 last, where symbol i is chk_syms[10*i+9:10*i].
- R3: If dec_syndrome is all zero after loading, the run ends with done and pass both high. dec_calc_start never rises, dec_val_rd does not pulse, and the buffer is left unchanged.
- R4: A non-zero syndrome raises dec_calc_start, which stays high until the run exits. The sequencer first waits for dec_state >= 4 and then for dec_state <= 3.
- R5: If dec_state is still above 3 after TMO cycles of the settle wait, the run ends with a fail.
- R6: A settled code of 0 ends the run with a pass. A settled code of 1 ends it with a fail. Neither writes the buffer.
- R7: A settled code of 2 or 3 applies dec_err_cnt+1 corrections. Slot k takes its location from dec_err_loc[10*k+9:10*k] and its pattern from dec_err_pat[8*k+7:8*k]. Slots above dec_err_cnt are ignored.
- R8: The byte offset is 519 minus the location. If the offset is above 511 or below 0, the run stops and fails, and corrections already written are kept.
- R9: Each correction XORs its pattern into the addressed byte with one read cycle and then one write cycle. Slots are processed from the highest index down to slot 0.
- R10: Every exit taken after dec_calc_start has risen pulses dec_val_rd for one cycle, in the same cycle as done, and dec_calc_start is low in that cycle.
- R11: done is a one-cycle pulse and pass holds the result of the run. A start seen while busy is ignored, and a host write seen while busy does not change the buffer.
- R12: While idle, host_we writes host_wdata to host_addr. host_rdata returns the byte at host_addr one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start a correction run |
| chk_syms | input | 80 | Eight stored check symbols, symbol i at bits 10*i+9:10*i |
| busy | output | 1 | Sequencer is not idle |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Result of the last run (1 = pass) |
| dec_load_valid | output | 1 | Check symbol is being presented to the decoder |
| dec_load_sym | output | 10 | Check symbol value |
| dec_syndrome | input | 80 | Eight 10-bit syndrome fields from the decoder |
| dec_calc_start | output | 1 | Correction calculation request |
| dec_state | input | 4 | Decoder state code |
| dec_err_cnt | input | 2 | Number of located errors minus one |
| dec_err_loc | input | 40 | Four 10-bit error locations |
| dec_err_pat | input | 32 | Four 8-bit error patterns |
| dec_val_rd | output | 1 | Read strobe of the first error-value word, clears the request |
| host_we | input | 1 | Host buffer write enable |
| host_addr | input | 9 | Host buffer address |
| host_wdata | input | 8 | Host buffer write data |
| host_rdata | output | 8 | Host buffer read data, one cycle latency |

## Verification
The collision of interest is a host write landing in the same cycle as a correction's write to the same byte. The sequencer owns the buffer while busy, so the correction must win and the host write must vanish. The bench holds a host write of 0x00 to offset 0 across a whole four-slot run whose first-processed slot maps to offset 0. It also sends a second start in the middle of that run. It then reads the byte back and expects the original value XORed with the pattern, and it expects exactly one done for the run.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_LOAD,
      S_SYN,
      S_RISE,
      S_FALL,
      S_FIX,
      S_PUT
   } nfc_st_e;

   localparam int CODE_CLEAN  = 0;
   localparam int CODE_LOST   = 1;
   localparam int CODE_SETTLE = 3;
   localparam int CODE_BUSY   = 4;
endpackage

// File: rtl/nfc_page_ram.sv
module nfc_page_ram #(
   parameter int DEPTH = 512,
   parameter int W     = 8,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
   end
endmodule

// File: rtl/nfc_wdog.sv
module nfc_wdog #(
   parameter int LIMIT = 1024,
   localparam int CW   = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
   input  logic clk,
   input  logic rst,
   input  logic run,
   output logic expired
);
   logic [CW-1:0] cnt;

   if (LIMIT < 2) begin : g_bad_limit
      $error("nfc_wdog: LIMIT must be at least 2");
   end

   assign expired = run && (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk) begin
      if (rst || !run) cnt <= '0;
      else if (!expired) cnt <= cnt + 1'b1;
   end

   // R5: the owner leaves the wait as soon as the limit is hit
   a_r5_leave_on_expiry: assert property (@(posedge clk) disable iff (rst)
      expired |=> !run);
endmodule

// File: rtl/nfc_slot_map.sv
module nfc_slot_map #(
   parameter int SYM_W  = 10,
   parameter int NSLOT  = 4,
   parameter int BYTES  = 512,
   parameter int DAT_W  = 8,
   parameter int BIAS   = 519,
   localparam int ADDR_W = $clog2(BYTES),
   localparam int CNT_W  = $clog2(NSLOT),
   localparam int DIFF_W = SYM_W + 1
) (
   input  logic [NSLOT*SYM_W-1:0] locs,
   input  logic [NSLOT*DAT_W-1:0] pats,
   input  logic [CNT_W-1:0]       sel,
   output logic [ADDR_W-1:0]      off,
   output logic [DAT_W-1:0]       pat,
   output logic                   bad
);
   logic [DIFF_W-1:0] diff [NSLOT];
   logic [NSLOT-1:0]  bad_v;

   if ((1 << SYM_W) <= BIAS) begin : g_bad_bias
      $error("nfc_slot_map: BIAS does not fit in a symbol");
   end
   if (ADDR_W > SYM_W) begin : g_bad_addr
      $error("nfc_slot_map: buffer wider than a symbol");
   end

   for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      assign diff[k]  = DIFF_W'(BIAS) - {1'b0, locs[k*SYM_W +: SYM_W]};
      assign bad_v[k] = diff[k][DIFF_W-1] ||
                        (diff[k][DIFF_W-2:0] > (DIFF_W-1)'(BYTES - 1));
   end

   assign off = diff[sel][ADDR_W-1:0];
   assign pat = pats[sel*DAT_W +: DAT_W];
   assign bad = bad_v[sel];
endmodule

// File: rtl/nand_ecc_fixer.sv
module nand_ecc_fixer
   import nfc_pkg::*;
#(
   parameter int SYM_W = 10,
   parameter int NSYM  = 8,
   parameter int NSLOT = 4,
   parameter int BYTES = 512,
   parameter int DAT_W = 8,
   parameter int ST_W  = 4,
   parameter int TMO   = 1024,
   localparam int ADDR_W = $clog2(BYTES),
   localparam int CNT_W  = $clog2(NSLOT),
   localparam int IDX_W  = $clog2(NSYM),
   localparam int BIAS   = BYTES + NSYM - 1
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   start,
   input  logic [NSYM*SYM_W-1:0]  chk_syms,
   output logic                   busy,
   output logic                   done,
   output logic                   pass,
   output logic                   dec_load_valid,
   output logic [SYM_W-1:0]       dec_load_sym,
   input  logic [NSYM*SYM_W-1:0]  dec_syndrome,
   output logic                   dec_calc_start,
   input  logic [ST_W-1:0]        dec_state,
   input  logic [CNT_W-1:0]       dec_err_cnt,
   input  logic [NSLOT*SYM_W-1:0] dec_err_loc,
   input  logic [NSLOT*DAT_W-1:0] dec_err_pat,
   output logic                   dec_val_rd,
   input  logic                   host_we,
   input  logic [ADDR_W-1:0]      host_addr,
   input  logic [DAT_W-1:0]       host_wdata,
   output logic [DAT_W-1:0]       host_rdata
);
   if (NSYM < 2) begin : g_bad_nsym
      $error("nand_ecc_fixer: NSYM must be at least 2");
   end
   if (NSLOT < 2 || (1 << CNT_W) != NSLOT) begin : g_bad_nslot
      $error("nand_ecc_fixer: NSLOT must be a power of two, at least 2");
   end
   if (ST_W < 3) begin : g_bad_stw
      $error("nand_ecc_fixer: ST_W must hold code 4");
   end

   nfc_st_e st, st_n;
   logic [IDX_W-1:0]       idx;
   logic [CNT_W-1:0]       slot;
   logic [ADDR_W-1:0]      off_q;
   logic [DAT_W-1:0]       pat_q;
   logic [NSYM*SYM_W-1:0]  syms_q;
   logic calc_q, done_q, pass_q, vrd_q;
   logic fin, fin_ok, fix_re, fix_we, wd_exp, syn_zero;
   logic settled;
   logic [ADDR_W-1:0] m_off;
   logic [DAT_W-1:0]  m_pat;
   logic              m_bad;
   logic              ram_we;
   logic [ADDR_W-1:0] ram_addr;
   logic [DAT_W-1:0]  ram_wdata, ram_rdata;

   assign syn_zero = (dec_syndrome == '0);
   assign settled  = (dec_state <= ST_W'(CODE_SETTLE));

   nfc_slot_map #(
      .SYM_W(SYM_W), .NSLOT(NSLOT), .BYTES(BYTES), .DAT_W(DAT_W), .BIAS(BIAS)
   ) u_map (
      .locs(dec_err_loc), .pats(dec_err_pat), .sel(slot),
      .off(m_off), .pat(m_pat), .bad(m_bad)
   );

   nfc_wdog #(.LIMIT(TMO)) u_wdog (
      .clk(clk), .rst(rst), .run(st == S_FALL), .expired(wd_exp)
   );

   always_comb begin
      st_n   = st;
      fin    = 1'b0;
      fin_ok = 1'b0;
      fix_re = 1'b0;
      fix_we = 1'b0;
      case (st)
         S_IDLE: if (start) st_n = S_LOAD;
         S_LOAD: if (idx == '0) st_n = S_SYN;
         S_SYN: begin
            if (syn_zero) begin
               fin    = 1'b1;
               fin_ok = 1'b1;
            end else begin
               st_n = S_RISE;
            end
         end
         S_RISE: if (dec_state >= ST_W'(CODE_BUSY)) st_n = S_FALL;
         S_FALL: begin
            if (settled) begin
               if (dec_state == ST_W'(CODE_CLEAN)) begin
                  fin    = 1'b1;
                  fin_ok = 1'b1;
               end else if (dec_state == ST_W'(CODE_LOST)) begin
                  fin = 1'b1;
               end else begin
                  st_n = S_FIX;
               end
            end else if (wd_exp) begin
               fin = 1'b1;
            end
         end
         S_FIX: begin
            if (m_bad) begin
               fin = 1'b1;
            end else begin
               fix_re = 1'b1;
               st_n   = S_PUT;
            end
         end
         S_PUT: begin
            fix_we = 1'b1;
            if (slot == '0) begin
               fin    = 1'b1;
               fin_ok = 1'b1;
            end else begin
               st_n = S_FIX;
            end
         end
         default: st_n = S_IDLE;
      endcase
      if (fin) st_n = S_IDLE;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st     <= S_IDLE;
         idx    <= '0;
         slot   <= '0;
         off_q  <= '0;
         pat_q  <= '0;
         syms_q <= '0;
         calc_q <= 1'b0;
         done_q <= 1'b0;
         pass_q <= 1'b0;
         vrd_q  <= 1'b0;
      end else begin
         st     <= st_n;
         done_q <= fin;
         vrd_q  <= fin && calc_q;
         if (fin) pass_q <= fin_ok;
         if (st == S_IDLE && start) begin
            syms_q <= chk_syms;
            idx    <= IDX_W'(NSYM - 1);
         end
         if (st == S_LOAD && idx != '0) idx <= idx - 1'b1;
         if (st == S_SYN && !syn_zero) calc_q <= 1'b1;
         if (fin) calc_q <= 1'b0;
         if (st == S_FALL && settled && st_n == S_FIX) slot <= dec_err_cnt;
         if (fix_re) begin
            off_q <= m_off;
            pat_q <= m_pat;
         end
         if (st == S_PUT && slot != '0) slot <= slot - 1'b1;
      end
   end

   assign busy           = (st != S_IDLE);
   assign done           = done_q;
   assign pass           = pass_q;
   assign dec_calc_start = calc_q;
   assign dec_val_rd     = vrd_q;
   assign dec_load_valid = (st == S_LOAD);
   assign dec_load_sym   = syms_q[idx*SYM_W +: SYM_W];

   assign ram_we    = busy ? fix_we : host_we;
   assign ram_addr  = !busy ? host_addr : ((st == S_PUT) ? off_q : m_off);
   assign ram_wdata = busy ? (ram_rdata ^ pat_q) : host_wdata;
   assign host_rdata = ram_rdata;

   nfc_page_ram #(.DEPTH(BYTES), .W(DAT_W)) u_ram (
      .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_rdata)
   );

   // R2: no load traffic while a calculation is requested
   a_r2_load_excl: assert property (@(posedge clk) disable iff (rst)
      dec_load_valid |-> !dec_calc_start);
   // R3: a clean syndrome ends quietly with a pass
   a_r3_quiet_finish: assert property (@(posedge clk) disable iff (rst)
      (st == S_SYN && syn_zero) |=> (done && pass && !dec_val_rd));
   // R9: every buffer write by the sequencer follows its read
   a_r9_rmw_pair: assert property (@(posedge clk) disable iff (rst)
      fix_we |-> $past(fix_re));
   // R10: the clearing strobe comes with done and a dropped request
   a_r10_clear_on_exit: assert property (@(posedge clk) disable iff (rst)
      dec_val_rd |-> (done && !dec_calc_start));
   // R11: done lasts one cycle
   a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
endmodule

// File: tb/nand_ecc_fixer_test.sv
module nand_ecc_fixer_test;
   localparam int CLK_NS = 10;
   localparam int TMO    = 40;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic start = 1'b0;
   logic [79:0] chk_syms = '0;
   logic busy, done, pass;
   logic dec_load_valid;
   logic [9:0] dec_load_sym;
   logic [79:0] dec_syndrome = '0;
   logic dec_calc_start;
   logic [3:0] dec_state;
   logic [1:0] dec_err_cnt = '0;
   logic [39:0] dec_err_loc = '0;
   logic [31:0] dec_err_pat = '0;
   logic dec_val_rd;
   logic host_we = 1'b0;
   logic [8:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;

   nand_ecc_fixer #(.TMO(TMO)) uut (
      .clk(clk), .rst(rst), .start(start), .chk_syms(chk_syms),
      .busy(busy), .done(done), .pass(pass),
      .dec_load_valid(dec_load_valid), .dec_load_sym(dec_load_sym),
      .dec_syndrome(dec_syndrome), .dec_calc_start(dec_calc_start),
      .dec_state(dec_state), .dec_err_cnt(dec_err_cnt),
      .dec_err_loc(dec_err_loc), .dec_err_pat(dec_err_pat),
      .dec_val_rd(dec_val_rd),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata)
   );

   always #(CLK_NS/2) clk = ~clk;

   int total = 0, bad = 0;
   int done_cnt = 0, vrd_cnt = 0, calc_cycles = 0;
   bit exp_q[$];
   int load_seen[$];
   logic [7:0] mem_img [512];

   // decoder model
   int ph = 0;
   int hi_len = 3;
   logic [3:0] fin_code = 4'd0;
   always @(posedge clk) begin
      if (rst || !dec_calc_start) ph <= 0;
      else ph <= ph + 1;
   end
   always_comb begin
      if (!dec_calc_start || ph < 2) dec_state = 4'd0;
      else if (ph < 2 + hi_len)      dec_state = 4'd5;
      else                           dec_state = fin_code;
   end

   task automatic check(bit ok, string tag, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      bit e;
      if (!rst) begin
         if (done) begin
            done_cnt++;
            if (exp_q.size() == 0) begin
               check(1'b0, "R11 unexpected done", 1, 0);
            end else begin
               e = exp_q.pop_front();
               check(pass == e, "R11 pass flag of run", int'(pass), int'(e));
            end
         end
         if (dec_val_rd) vrd_cnt++;
         if (dec_calc_start) calc_cycles++;
         if (dec_load_valid) load_seen.push_back(int'(dec_load_sym));
      end
   end

   task automatic host_wr(int a, int d);
      @(negedge clk);
      host_we = 1'b1; host_addr = a[8:0]; host_wdata = d[7:0];
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic host_rd(int a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a[8:0];
      @(negedge clk);
      d = host_rdata;
   endtask

   task automatic chk_byte(int a, string tag);
      logic [7:0] v;
      host_rd(a, v);
      check(v == mem_img[a], tag, int'(v), int'(mem_img[a]));
   endtask

   task automatic set_slot(int k, int loc, int pat);
      dec_err_loc[k*10 +: 10] = loc[9:0];
      dec_err_pat[k*8 +: 8]   = pat[7:0];
   endtask

   task automatic run(bit exp_pass);
      int d0;
      exp_q.push_back(exp_pass);
      vrd_cnt = 0; calc_cycles = 0; load_seen.delete();
      d0 = done_cnt;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (done_cnt == d0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      #(CLK_NS * 100000);
      check(1'b0, "watchdog expired", 0, 1);
      summary();
      $finish;
   end

   initial begin
      int mism, d1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      check(done == 0 && pass == 0 && busy == 0, "R1 done/pass/busy after reset",
            int'({done, pass, busy}), 0);
      check(dec_load_valid == 0 && dec_calc_start == 0 && dec_val_rd == 0,
            "R1 decoder strobes after reset",
            int'({dec_load_valid, dec_calc_start, dec_val_rd}), 0);

      for (int s = 0; s < 8; s++) chk_syms[s*10 +: 10] = 10'(s*37 + 5);
      for (int i = 0; i < 512; i++) begin
         mem_img[i] = 8'(i*7 + 3);
         host_wr(i, int'(mem_img[i]));
      end
      // R12: idle host write then read back
      chk_byte(100, "R12 host readback");
      host_wr(100, 8'h3C); mem_img[100] = 8'h3C;
      chk_byte(100, "R12 host write while idle");

      // R3 and R2: clean syndrome, unmasked bits absent
      dec_syndrome = '0;
      run(1'b1);
      check(load_seen.size() == 8, "R2 number of loaded symbols", load_seen.size(), 8);
      mism = 0;
      for (int j = 0; j < load_seen.size() && j < 8; j++)
         if (load_seen[j] != (7 - j)*37 + 5) mism++;
      check(mism == 0, "R2 descending load order", mism, 0);
      check(calc_cycles == 0, "R3 no calc request", calc_cycles, 0);
      check(vrd_cnt == 0, "R3 no clearing strobe", vrd_cnt, 0);
      chk_byte(0, "R3 buffer untouched");

      // R6 code 0
      dec_syndrome[37] = 1'b1;
      fin_code = 4'd0; hi_len = 3;
      run(1'b1);
      check(calc_cycles > 3, "R4 calc request held through wait", calc_cycles, 4);
      check(vrd_cnt == 1, "R10 one clearing strobe on code 0", vrd_cnt, 1);
      chk_byte(0, "R6 code 0 no write");

      // R6 code 1
      fin_code = 4'd1;
      run(1'b0);
      check(vrd_cnt == 1, "R10 one clearing strobe on code 1", vrd_cnt, 1);
      chk_byte(0, "R6 code 1 no write");

      // R7 R8 R9 R11: four corrections, colliding host write and extra start
      fin_code = 4'd3; dec_err_cnt = 2'd3;
      set_slot(0, 300, 8'hF0);
      set_slot(1, 100, 8'h11);
      set_slot(2, 8,   8'hC3);
      set_slot(3, 519, 8'h5A);
      mem_img[219] ^= 8'hF0; mem_img[419] ^= 8'h11;
      mem_img[511] ^= 8'hC3; mem_img[0]   ^= 8'h5A;
      fork
         run(1'b1);
         begin
            wait (busy);
            repeat (3) @(negedge clk);
            start = 1'b1; host_we = 1'b1; host_addr = 9'd0; host_wdata = 8'h00;
            @(negedge clk);
            start = 1'b0;
            while (!done) @(negedge clk);
            host_we = 1'b0;
         end
      join
      d1 = done_cnt;
      repeat (30) @(negedge clk);
      check(done_cnt == d1, "R11 start while busy ignored", done_cnt, d1);
      chk_byte(0,   "R11 R8 host write lost, offset 0 from loc 519");
      chk_byte(511, "R8 loc 8 maps to 511");
      chk_byte(419, "R9 slot 1 xor");
      chk_byte(219, "R7 slot 0 applied");
      check(vrd_cnt == 1, "R10 strobe after corrections", vrd_cnt, 1);

      // R7: code 2, one error; slot 1 holds a bad location and must be ignored
      fin_code = 4'd2; dec_err_cnt = 2'd0;
      set_slot(0, 200, 8'h55);
      set_slot(1, 520, 8'hFF);
      mem_img[319] ^= 8'h55;
      run(1'b1);
      chk_byte(319, "R7 single correction with code 2");

      // R9 order and R8: slot 1 bad stops before slot 0
      fin_code = 4'd3; dec_err_cnt = 2'd1;
      set_slot(0, 300, 8'h0F);
      set_slot(1, 5, 8'hAA);
      run(1'b0);
      chk_byte(219, "R9 highest slot first, stop on bad");
      check(vrd_cnt == 1, "R10 strobe on bad-offset exit", vrd_cnt, 1);

      // R8: loc 7 gives 512, loc 520 gives negative
      dec_err_cnt = 2'd0;
      set_slot(0, 7, 8'h01);
      run(1'b0);
      chk_byte(511, "R8 offset 512 rejected");
      set_slot(0, 520, 8'h01);
      run(1'b0);
      chk_byte(0, "R8 negative offset rejected");

      // R5: decoder never settles
      fin_code = 4'd6;
      run(1'b0);
      check(calc_cycles >= TMO, "R5 timeout waited", calc_cycles, TMO);
      check(vrd_cnt == 1, "R10 strobe on timeout", vrd_cnt, 1);
      check(exp_q.size() == 0, "R11 all runs reported", exp_q.size(), 0);

      summary();
      $finish;
   end
endmodule